// File: doc/BRIEF.md
# Deferred Reply Tracker

This block sits on the requesting side of a split-transaction bus. When a target answers an outgoing request with a deferral, the requester notes the request here. The note holds the request's type and the 8-bit tag that the target assigned to it. Some time later the target sends a reply in its own bus transaction. Replies can come back in any order. The tracker pulls the tag out of the reply's second address word, finds the pending entry with that tag, and closes the entry.

A matched reply either completes the request as though it had never been deferred, or sends it back for reissue. Completion passes through the snoop hit and modified-hit flags and whether data was returned. Reissue happens when the reply carries a retry response or asserts its defer snoop flag.

The tracker also handles the cases that should not occur:
- A reply that is itself a deferral is a protocol error.
- A reply whose tag matches no pending entry raises an error.
- A notification that uses a reserved request type is ignored.
- A notification that repeats a tag already pending is ignored.

Each of these leaves the table unchanged.

Top module: `srt_tracker`

## Requirements
- R1: After reset the table is empty. `note_ready` is 1, and every pulse output (`done_valid`, `retry_valid`, `err_unmatched`, `err_proto`) is 0.
- R2: A notification is accepted when `note_valid` is 1, `note_ready` is 1, the type is not reserved and the tag is not already pending. The accepted entry can be matched by any reply from the following cycle on.
- R3: `note_ready` is 0 exactly when all `ENTRIES` slots are occupied. A notification presented while `note_ready` is 0 is dropped.
- R4: The reply tag is taken from `rpl_addr[TAG_LSB +: TAG_W]` (bits 23..16 by default). Every other address bit is ignored. The tag of the reply is shown on `out_tag` with each reply result.
- R5: Some matched replies complete normally. These have a response code of 2'b00 (complete, no data) or 2'b11 (complete with data), with `rpl_defer` at 0. Such a reply raises `done_valid` for one cycle, one clock after the reply. With it come the entry's type, `rpl_hit`, `rpl_hitm`, and `out_data` = `rpl_data_valid` AND code 2'b11. The entry is freed on that same edge.
- R6: A matched reply with response code 2'b01 (retry), or with `rpl_defer` at 1, raises `retry_valid` one clock later, together with the entry's type. It does not raise `done_valid`, and it frees the entry.
- R7: A reply with response code 2'b10 (deferred) raises `err_proto` one clock later, whether or not its tag matches. The matching entry stays pending.
- R8: A reply with any other code whose tag matches no pending entry raises `err_unmatched` one clock later and changes no entry.
- R9: A notification whose 3-bit type has its upper two bits both 1 (codes 6 and 7) is reserved. It is ignored and no entry is created.
- R10: A notification whose tag equals that of a pending entry is ignored. The existing entry keeps its type.
- R11: A reply and a notification in the same cycle are both handled. A slot freed by that reply cannot be taken before the next cycle. On a full table `note_ready` stays 0 during the reply cycle and becomes 1 one clock later.
- R12: In any cycle at most one of `done_valid`, `retry_valid`, `err_unmatched` and `err_proto` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| note_valid | input | 1 | Deferral notification present |
| note_tag | input | TAG_W | Tag assigned by the target |
| note_type | input | 3 | Request type of the deferred request |
| note_ready | output | 1 | A free slot exists |
| rpl_valid | input | 1 | Deferred reply present |
| rpl_addr | input | ADDR_W | Second address word of the reply |
| rpl_resp | input | 2 | Reply response code |
| rpl_hit | input | 1 | Snoop hit seen on the reply |
| rpl_hitm | input | 1 | Snoop modified-hit seen on the reply |
| rpl_defer | input | 1 | Defer snoop flag seen on the reply |
| rpl_data_valid | input | 1 | Reply returned data |
| done_valid | output | 1 | Entry completed normally (pulse) |
| retry_valid | output | 1 | Entry must be reissued (pulse) |
| out_tag | output | TAG_W | Tag of the reply just handled |
| out_type | output | 3 | Type of the closed entry |
| out_hit | output | 1 | Hit flag for the completion |
| out_hitm | output | 1 | Modified-hit flag for the completion |
| out_data | output | 1 | Completion carried data |
| err_unmatched | output | 1 | Reply tag matched nothing (pulse) |
| err_proto | output | 1 | Reply carried a deferred code (pulse) |

## Verification
The bench builds the tracker with `ENTRIES` = 4 and keeps the default tag position and width. With four slots, filling the table takes only a few cycles, so the full-table refusal and the one-cycle delay before a freed slot can be reused are easy to reach. A retirement on a full table can then be placed in the same cycle as a refused notification. The default tag field keeps the bit 23..16 extraction under test, with other address bits changing.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int TYPE_W = 3;

    typedef enum logic [1:0] {
        RSP_NODATA = 2'b00,
        RSP_RETRY  = 2'b01,
        RSP_DEFER  = 2'b10,
        RSP_DATA   = 2'b11
    } rsp_e;

    function automatic logic type_reserved(input logic [TYPE_W-1:0] t);
        return (t[TYPE_W-1:TYPE_W-2] == 2'b11);
    endfunction

endpackage

// File: rtl/srt_alloc.sv
module srt_alloc #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    logic [N-1:0] free_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_free
            assign free_vec[g] = ~busy[g];
        end
    endgenerate

    assign any_free = |free_vec;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/srt_match.sv
module srt_match #(
    parameter int N     = 8,
    parameter int TAG_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            live,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);
    logic [N-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign eq[g] = live[g] && (tags[g] == key);
        end
    endgenerate

    assign hit = |eq;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/srt_tracker.sv
module srt_tracker
    import srt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 8,
    parameter int ADDR_W  = 24,
    parameter int TAG_LSB = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 note_valid,
    input  logic [TAG_W-1:0]     note_tag,
    input  logic [TYPE_W-1:0]    note_type,
    output logic                 note_ready,
    input  logic                 rpl_valid,
    input  logic [ADDR_W-1:0]    rpl_addr,
    input  logic [1:0]           rpl_resp,
    input  logic                 rpl_hit,
    input  logic                 rpl_hitm,
    input  logic                 rpl_defer,
    input  logic                 rpl_data_valid,
    output logic                 done_valid,
    output logic                 retry_valid,
    output logic [TAG_W-1:0]     out_tag,
    output logic [TYPE_W-1:0]    out_type,
    output logic                 out_hit,
    output logic                 out_hitm,
    output logic                 out_data,
    output logic                 err_unmatched,
    output logic                 err_proto
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][TYPE_W-1:0] typ;
        logic                           done;
        logic                           retry;
        logic [TAG_W-1:0]               o_tag;
        logic [TYPE_W-1:0]              o_type;
        logic                           o_hit;
        logic                           o_hitm;
        logic                           o_data;
        logic                           e_unm;
        logic                           e_proto;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0] rpl_key;
    logic             rpl_hit_any, note_dup, slot_free;
    logic [IDX_W-1:0] rpl_idx, note_dup_idx, slot_idx;
    rsp_e             rsp;

    assign rpl_key = rpl_addr[TAG_LSB +: TAG_W];
    assign rsp     = rsp_e'(rpl_resp);

    srt_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_rpl_match (
        .live    (st_q.vld),
        .tags    (st_q.tag),
        .key     (rpl_key),
        .hit     (rpl_hit_any),
        .hit_idx (rpl_idx)
    );

    srt_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_note_match (
        .live    (st_q.vld),
        .tags    (st_q.tag),
        .key     (note_tag),
        .hit     (note_dup),
        .hit_idx (note_dup_idx)
    );

    srt_alloc #(.N(ENTRIES)) u_alloc (
        .busy     (st_q.vld),
        .any_free (slot_free),
        .free_idx (slot_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.retry   = 1'b0;
        st_d.e_unm   = 1'b0;
        st_d.e_proto = 1'b0;
        st_d.o_hit   = 1'b0;
        st_d.o_hitm  = 1'b0;
        st_d.o_data  = 1'b0;

        if (rpl_valid) begin
            st_d.o_tag = rpl_key;
            if (rsp == RSP_DEFER) begin
                st_d.e_proto = 1'b1;
            end else if (!rpl_hit_any) begin
                st_d.e_unm = 1'b1;
            end else begin
                st_d.vld[rpl_idx] = 1'b0;
                st_d.o_type       = st_q.typ[rpl_idx];
                if (rsp == RSP_RETRY || rpl_defer) begin
                    st_d.retry = 1'b1;
                end else begin
                    st_d.done   = 1'b1;
                    st_d.o_hit  = rpl_hit;
                    st_d.o_hitm = rpl_hitm;
                    st_d.o_data = rpl_data_valid && (rsp == RSP_DATA);
                end
            end
        end

        // Allocation looks only at the registered table, so a slot retired
        // in this cycle is not reused until the next one.
        if (note_valid && slot_free && !type_reserved(note_type) && !note_dup) begin
            st_d.vld[slot_idx] = 1'b1;
            st_d.tag[slot_idx] = note_tag;
            st_d.typ[slot_idx] = note_type;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign note_ready    = slot_free;
    assign done_valid    = st_q.done;
    assign retry_valid   = st_q.retry;
    assign out_tag       = st_q.o_tag;
    assign out_type      = st_q.o_type;
    assign out_hit       = st_q.o_hit;
    assign out_hitm      = st_q.o_hitm;
    assign out_data      = st_q.o_data;
    assign err_unmatched = st_q.e_unm;
    assign err_proto     = st_q.e_proto;

    logic unused_dup_idx;
    assign unused_dup_idx = ^note_dup_idx;

endmodule

// File: rtl/srt_tracker_chk.sv
module srt_tracker_chk #(
    parameter int TAG_W   = 8,
    parameter int ADDR_W  = 24,
    parameter int TAG_LSB = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              note_ready,
    input logic              rpl_valid,
    input logic [ADDR_W-1:0] rpl_addr,
    input logic [1:0]        rpl_resp,
    input logic              rpl_defer,
    input logic              done_valid,
    input logic              retry_valid,
    input logic [TAG_W-1:0]  out_tag,
    input logic              err_unmatched,
    input logic              err_proto
);
    a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_valid, retry_valid, err_unmatched, err_proto}));

    a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(rpl_valid) && !$past(rpl_defer) &&
                        ($past(rpl_resp) == 2'b00 || $past(rpl_resp) == 2'b11)));

    a_r6_retry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid |-> ($past(rpl_valid) &&
                         ($past(rpl_resp) == 2'b01 || $past(rpl_defer))));

    a_r7_proto_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && rpl_resp == 2'b10) |=> (err_proto && !done_valid && !retry_valid));

    a_r4_tag_field: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || retry_valid) |-> (out_tag == $past(rpl_addr[TAG_LSB +: TAG_W])));

    a_r3_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!note_ready && !rpl_valid) |=> !note_ready);
endmodule

bind srt_tracker srt_tracker_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .note_ready    (note_ready),
    .rpl_valid     (rpl_valid),
    .rpl_addr      (rpl_addr),
    .rpl_resp      (rpl_resp),
    .rpl_defer     (rpl_defer),
    .done_valid    (done_valid),
    .retry_valid   (retry_valid),
    .out_tag       (out_tag),
    .err_unmatched (err_unmatched),
    .err_proto     (err_proto)
);

// File: tb/srt_tracker_bench.sv
module srt_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic note_valid = 0; logic [7:0] note_tag = 0; logic [2:0] note_type = 0;
    logic rpl_valid = 0; logic [23:0] rpl_addr = 0; logic [1:0] rpl_resp = 0;
    logic rpl_hit = 0, rpl_hitm = 0, rpl_defer = 0, rpl_data_valid = 0;
    logic note_ready, done_valid, retry_valid, out_hit, out_hitm, out_data;
    logic err_unmatched, err_proto;
    logic [7:0] out_tag; logic [2:0] out_type;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srt_tracker #(.ENTRIES(N)) u_srt_tracker (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive both ports for one clock; on return the registered results are visible.
    task automatic step(input bit nv, input logic [7:0] nt, input logic [2:0] ny,
                        input bit rv, input logic [7:0] rt, input logic [1:0] rr,
                        input bit dv, input bit h, input bit hm, input bit df);
        note_valid = nv; note_tag = nt; note_type = ny;
        rpl_valid = rv; rpl_addr = {rt, 16'hC3A5 ^ {8'h0, rt}}; rpl_resp = rr;
        rpl_data_valid = dv; rpl_hit = h; rpl_hitm = hm; rpl_defer = df;
        @(negedge clk);
        note_valid = 0; rpl_valid = 0; rpl_defer = 0; rpl_hit = 0; rpl_hitm = 0;
        rpl_data_valid = 0;
    endtask

    task automatic note(input logic [7:0] t, input logic [2:0] y);
        step(1, t, y, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic reply(input logic [7:0] t, input logic [1:0] r, input bit dv,
                         input bit h, input bit hm, input bit df);
        step(0, 0, 0, 1, t, r, dv, h, hm, df);
    endtask

    task automatic expect_done(input string req, input logic [7:0] t, input logic [2:0] y,
                               input bit h, input bit hm, input bit d);
        chk(done_valid && !retry_valid, {req, " done"}, done_valid, 1);
        chk(out_tag == t, {req, " tag"}, out_tag, t);
        chk(out_type == y, {req, " type"}, out_type, y);
        chk({out_hit, out_hitm, out_data} == {h, hm, d}, {req, " flags"},
            {out_hit, out_hitm, out_data}, {h, hm, d});
    endtask

    task automatic t_reset;
        chk(note_ready == 1, "R1 ready", note_ready, 1);
        chk({done_valid, retry_valid, err_unmatched, err_proto} == 0, "R1 pulses",
            {done_valid, retry_valid, err_unmatched, err_proto}, 0);
    endtask

    task automatic t_basic;
        note(8'h5A, 3'd1);
        reply(8'h5A, 2'b11, 1, 1, 0, 0);
        expect_done("R2 R4 R5 data", 8'h5A, 3'd1, 1, 0, 1);
        @(negedge clk);
        chk(done_valid == 0, "R5 single pulse", done_valid, 0);
        reply(8'h5A, 2'b11, 1, 0, 0, 0);
        chk(err_unmatched == 1, "R8 freed entry unmatched", err_unmatched, 1);
        note(8'h21, 3'd2);
        reply(8'h21, 2'b00, 1, 0, 1, 0);
        expect_done("R5 nodata", 8'h21, 3'd2, 0, 1, 0);
    endtask

    task automatic t_retry;
        note(8'h33, 3'd4);
        reply(8'h33, 2'b01, 1, 0, 0, 0);
        chk(retry_valid && !done_valid, "R6 retry code", retry_valid, 1);
        chk(out_type == 3'd4, "R6 type", out_type, 4);
        note(8'h34, 3'd5);
        reply(8'h34, 2'b11, 1, 1, 0, 1);
        chk(retry_valid && !done_valid, "R6 defer flag", retry_valid, 1);
        reply(8'h34, 2'b11, 1, 0, 0, 0);
        chk(err_unmatched == 1, "R6 entry freed", err_unmatched, 1);
    endtask

    task automatic t_proto;
        note(8'h90, 3'd0);
        reply(8'h90, 2'b10, 0, 0, 0, 0);
        chk(err_proto && !done_valid && !err_unmatched, "R7 proto", err_proto, 1);
        reply(8'h90, 2'b00, 0, 0, 0, 0);
        expect_done("R7 entry kept", 8'h90, 3'd0, 0, 0, 0);
        reply(8'hEE, 2'b10, 0, 0, 0, 0);
        chk(err_proto && !err_unmatched, "R7 unmatched proto", err_proto, 1);
    endtask

    task automatic t_reserved_dup;
        note(8'h44, 3'd6);
        reply(8'h44, 2'b11, 1, 0, 0, 0);
        chk(err_unmatched == 1, "R9 reserved 6", err_unmatched, 1);
        note(8'h45, 3'd7);
        reply(8'h45, 2'b11, 1, 0, 0, 0);
        chk(err_unmatched == 1, "R9 reserved 7", err_unmatched, 1);
        note(8'h50, 3'd3);
        note(8'h50, 3'd5);
        reply(8'h50, 2'b00, 0, 0, 0, 0);
        expect_done("R10 first type", 8'h50, 3'd3, 0, 0, 0);
        reply(8'h50, 2'b00, 0, 0, 0, 0);
        chk(err_unmatched == 1, "R10 no second entry", err_unmatched, 1);
    endtask

    task automatic t_full;
        for (int i = 0; i < N; i++) note(8'hA0 + 8'(i), 3'(i));
        chk(note_ready == 0, "R3 full", note_ready, 0);
        note(8'h77, 3'd1);
        reply(8'h77, 2'b00, 0, 0, 0, 0);
        chk(err_unmatched == 1, "R3 dropped note", err_unmatched, 1);
        // retire one and offer a note in the same cycle while full
        step(1, 8'h78, 3'd2, 1, 8'hA1, 2'b11, 1, 0, 0, 0);
        expect_done("R11 retire on full", 8'hA1, 3'd1, 0, 0, 1);
        chk(note_ready == 1, "R11 ready next cycle", note_ready, 1);
        reply(8'h78, 2'b00, 0, 0, 0, 0);
        chk(err_unmatched == 1, "R11 same-cycle note refused", err_unmatched, 1);
        // both ports together with a free slot
        step(1, 8'h79, 3'd5, 1, 8'hA0, 2'b00, 0, 1, 1, 0);
        expect_done("R11 concurrent reply", 8'hA0, 3'd0, 1, 1, 0);
        reply(8'h79, 2'b11, 1, 0, 0, 0);
        expect_done("R11 concurrent note", 8'h79, 3'd5, 0, 0, 1);
        reply(8'hA2, 2'b00, 0, 0, 0, 0);
        reply(8'hA3, 2'b00, 0, 0, 0, 0);
        chk(done_valid && note_ready, "R3 drained", done_valid, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_retry;
        t_proto;
        t_reserved_dup;
        t_full;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule